// File: doc/BRIEF.md
# Debug Access Command Router

The router takes one debug access request at a time. A request is made of an 8-bit command code, an address, a direction bit and two 32-bit write words. The command code picks one internal target: the control-register bus, a 32-bit agent register reached over a sideband bus, a private scratch SRAM, a shared staging SRAM (two windows), I/O ports of 8, 16, 32 or 64 bits, the power-control sideband agent, or a procedure-call engine. The router shapes the write data and sideband opcode for that target. It holds the request on a single shared target bus until the target returns a done pulse.

Read data is narrowed to the target's width, so the unused upper bits come back as zero. The result is returned as a 64-bit primary word and a 32-bit auxiliary word. The auxiliary word normally repeats bits 63:32 of the primary word. For sideband agent accesses it carries the bus completion code instead. A code the router does not know, or a write-only code sent in a read request, is refused in the next cycle with an error flag and touches no target.

Top module: `dbg_access_router`

## Requirements
- R1: Command codes map to target codes on `tgt_id` as follows. 0x00 gives 0 (control bus, 64-bit). 0x08 gives 1 (agent, 32-bit). 0x10 gives 2 (scratch, 64-bit). 0x40 gives 3 with `tgt_alt`=0, and 0x80 gives 3 with `tgt_alt`=1 (staging, 64-bit). 0x18, 0x48, 0x50 and 0x58 give 4 (port) with `tgt_size` 0, 1, 2 and 3 (8, 16, 32 and 64 bits). Write-only codes: 0xC8 gives 1 (32-bit) and 0xD0 gives 5 (power agent, 32-bit). `tgt_size` encodes 8/16/32/64 bits as 0/1/2/3.
- R2: In a read response, `rsp_data` holds the target's returned data masked to the target width, with all higher bits zero.
- R3: `rsp_aux` equals `rsp_data[63:32]` for every response that is not an agent (`tgt_id`=1) access.
- R4: Command 0x08 drives `tgt_op` 0x05 on reads and 0x07 on writes. For agent accesses (0x08 and 0xC8) `rsp_aux` carries `tgt_status` and not data.
- R5: A 0xC8 write drives `tgt_op` = `req_wdata_hi[7:0]` and `tgt_wdata` = `req_wdata_lo` zero-extended.
- R6: A write to a 64-bit target drives `tgt_wdata` = {`req_wdata_hi`, `req_wdata_lo`}. A write to a narrower target drives `req_wdata_lo` masked to the target width and ignores `req_wdata_hi`.
- R7: An unknown code, or 0xC8/0xD0/0xD8 in a read, gives `rsp_valid` one cycle after acceptance, with `rsp_err`=1, all-zero data and aux, and no `tgt_req` or `proc_req`.
- R8: Only one request is in flight. `req_ready` is low from acceptance until the response cycle, and the target request fields stay stable until `tgt_done`.
- R9: A 0xD8 write raises `proc_req` with `proc_entry` = address, holds it until `proc_ack`, then responds with zero data and no error.
- R10: A 0xD0 write drives `tgt_op` 0x07. All non-agent targets get `tgt_op` 0.
- R11: After reset `req_ready`=1 and `rsp_valid`, `tgt_req` and `proc_req` are 0. A legal access responds in the cycle after `tgt_done` or `proc_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cmd | input | 8 | Command code |
| req_addr | input | ADDR_W | Target address / procedure entry |
| req_wdata_hi | input | 32 | High write word / 0xC8 opcode |
| req_wdata_lo | input | 32 | Low write word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 64 | Primary result word |
| rsp_aux | output | 32 | Auxiliary result word |
| rsp_err | output | 1 | Request refused |
| tgt_req | output | 1 | Target access pending |
| tgt_id | output | 3 | Target code |
| tgt_alt | output | 1 | Staging second window |
| tgt_write | output | 1 | Access direction |
| tgt_size | output | 2 | Access width code |
| tgt_addr | output | ADDR_W | Target address |
| tgt_wdata | output | 64 | Shaped write data |
| tgt_op | output | 8 | Sideband opcode |
| tgt_done | input | 1 | Target completion pulse |
| tgt_rdata | input | 64 | Target read data |
| tgt_status | input | 32 | Sideband completion code |
| proc_req | output | 1 | Procedure call pending |
| proc_entry | output | ADDR_W | Procedure entry point |
| proc_ack | input | 1 | Procedure call accepted |

## Verification
The assertions check, on every cycle, that only one request is in flight and that held request fields stay stable. They also check that refused requests return zeros without touching a target, that fixed agent opcodes are used, and that narrow writes and 8-bit reads keep their upper bits clear. The full decode table, mask widths for every port size, the mirroring of the auxiliary word, status routing and response latency depend on data the stub targets return. Only the bench scenarios show these, using random codes, random garbage read data and variable target latency.

// File: rtl/dbg_access_pkg.sv
package dbg_access_pkg;

  typedef enum logic [2:0] {
    TGT_CRB     = 3'd0,
    TGT_SYSAG   = 3'd1,
    TGT_SCRATCH = 3'd2,
    TGT_STAGE   = 3'd3,
    TGT_PORT    = 3'd4,
    TGT_POWER   = 3'd5
  } tgt_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } size_e;

  localparam logic [7:0] CMD_CRB    = 8'h00;
  localparam logic [7:0] CMD_SYSAG  = 8'h08;
  localparam logic [7:0] CMD_SCR    = 8'h10;
  localparam logic [7:0] CMD_PORT8  = 8'h18;
  localparam logic [7:0] CMD_STG    = 8'h40;
  localparam logic [7:0] CMD_PORT16 = 8'h48;
  localparam logic [7:0] CMD_PORT32 = 8'h50;
  localparam logic [7:0] CMD_PORT64 = 8'h58;
  localparam logic [7:0] CMD_STG2   = 8'h80;
  localparam logic [7:0] CMD_SAOP   = 8'hC8;
  localparam logic [7:0] CMD_PWR    = 8'hD0;
  localparam logic [7:0] CMD_PROC   = 8'hD8;

  localparam logic [7:0] SB_OP_RD = 8'h05;
  localparam logic [7:0] SB_OP_WR = 8'h07;

  typedef struct packed {
    logic  legal;
    logic  is_proc;
    tgt_e  tgt;
    size_e size;
    logic  alt;
    logic  sa_custom;
  } route_t;

  function automatic logic [63:0] width_mask(size_e s);
    case (s)
      SZ_8:    width_mask = 64'h0000_0000_0000_00FF;
      SZ_16:   width_mask = 64'h0000_0000_0000_FFFF;
      SZ_32:   width_mask = 64'h0000_0000_FFFF_FFFF;
      default: width_mask = '1;
    endcase
  endfunction

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_access_pkg::*;
(
  input  logic       write,
  input  logic [7:0] cmd,
  output route_t     route
);
  always_comb begin
    route = '{legal: 1'b1, is_proc: 1'b0, tgt: TGT_CRB, size: SZ_64,
              alt: 1'b0, sa_custom: 1'b0};
    case (cmd)
      CMD_CRB:    route.tgt = TGT_CRB;
      CMD_SYSAG:  begin route.tgt = TGT_SYSAG; route.size = SZ_32; end
      CMD_SCR:    route.tgt = TGT_SCRATCH;
      CMD_STG:    route.tgt = TGT_STAGE;
      CMD_STG2:   begin route.tgt = TGT_STAGE; route.alt = 1'b1; end
      CMD_PORT8:  begin route.tgt = TGT_PORT; route.size = SZ_8;  end
      CMD_PORT16: begin route.tgt = TGT_PORT; route.size = SZ_16; end
      CMD_PORT32: begin route.tgt = TGT_PORT; route.size = SZ_32; end
      CMD_PORT64: route.tgt = TGT_PORT;
      CMD_SAOP: begin
        route.tgt = TGT_SYSAG; route.size = SZ_32; route.sa_custom = 1'b1;
        route.legal = write;
      end
      CMD_PWR: begin
        route.tgt = TGT_POWER; route.size = SZ_32; route.legal = write;
      end
      CMD_PROC: begin
        route.is_proc = 1'b1; route.legal = write;
      end
      default: route.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dbg_wr_shaper.sv
module dbg_wr_shaper
  import dbg_access_pkg::*;
(
  input  route_t      route,
  input  logic        write,
  input  logic [31:0] wdata_hi,
  input  logic [31:0] wdata_lo,
  output logic [63:0] wdata,
  output logic [7:0]  op
);
  always_comb begin
    if (route.sa_custom) begin
      wdata = {32'd0, wdata_lo};
      op    = wdata_hi[7:0];
    end else begin
      wdata = {wdata_hi, wdata_lo} & width_mask(route.size);
      case (route.tgt)
        TGT_SYSAG: op = write ? SB_OP_WR : SB_OP_RD;
        TGT_POWER: op = SB_OP_WR;
        default:   op = 8'd0;
      endcase
    end
    if (!write) wdata = '0;
  end
endmodule

// File: rtl/dbg_rd_shaper.sv
module dbg_rd_shaper
  import dbg_access_pkg::*;
(
  input  logic        write,
  input  logic        is_agent,
  input  size_e       size,
  input  logic [63:0] rdata,
  input  logic [31:0] status,
  output logic [63:0] data,
  output logic [31:0] aux
);
  always_comb begin
    data = write ? 64'd0 : (rdata & width_mask(size));
    aux  = is_agent ? status : data[63:32];
  end
endmodule

// File: rtl/dbg_access_router.sv
module dbg_access_router
  import dbg_access_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata_hi,
  input  logic [31:0]       req_wdata_lo,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic [31:0]       rsp_aux,
  output logic              rsp_err,
  output logic              tgt_req,
  output logic [2:0]        tgt_id,
  output logic              tgt_alt,
  output logic              tgt_write,
  output logic [1:0]        tgt_size,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [63:0]       tgt_wdata,
  output logic [7:0]        tgt_op,
  input  logic              tgt_done,
  input  logic [63:0]       tgt_rdata,
  input  logic [31:0]       tgt_status,
  output logic              proc_req,
  output logic [ADDR_W-1:0] proc_entry,
  input  logic              proc_ack
);
  typedef enum logic [1:0] {ST_IDLE, ST_TGT, ST_PROC} state_e;

  state_e      state;
  route_t      dec;
  logic [63:0] shaped_wdata;
  logic [7:0]  shaped_op;
  logic [63:0] rd_data;
  logic [31:0] rd_aux;
  logic        sa_custom_q;
  logic        accept;

  dbg_cmd_decode u_decode (
    .write (req_write),
    .cmd   (req_cmd),
    .route (dec)
  );

  dbg_wr_shaper u_wshape (
    .route    (dec),
    .write    (req_write),
    .wdata_hi (req_wdata_hi),
    .wdata_lo (req_wdata_lo),
    .wdata    (shaped_wdata),
    .op       (shaped_op)
  );

  dbg_rd_shaper u_rshape (
    .write    (tgt_write),
    .is_agent (tgt_id == TGT_SYSAG),
    .size     (size_e'(tgt_size)),
    .rdata    (tgt_rdata),
    .status   (tgt_status),
    .data     (rd_data),
    .aux      (rd_aux)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_aux     <= '0;
      rsp_err     <= 1'b0;
      tgt_req     <= 1'b0;
      tgt_id      <= '0;
      tgt_alt     <= 1'b0;
      tgt_write   <= 1'b0;
      tgt_size    <= '0;
      tgt_addr    <= '0;
      tgt_wdata   <= '0;
      tgt_op      <= '0;
      sa_custom_q <= 1'b0;
      proc_req    <= 1'b0;
      proc_entry  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!dec.legal) begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_data  <= '0;
              rsp_aux   <= '0;
            end else if (dec.is_proc) begin
              proc_req   <= 1'b1;
              proc_entry <= req_addr;
              state      <= ST_PROC;
            end else begin
              tgt_req     <= 1'b1;
              tgt_id      <= dec.tgt;
              tgt_alt     <= dec.alt;
              tgt_write   <= req_write;
              tgt_size    <= dec.size;
              tgt_addr    <= req_addr;
              tgt_wdata   <= shaped_wdata;
              tgt_op      <= shaped_op;
              sa_custom_q <= dec.sa_custom;
              state       <= ST_TGT;
            end
          end
        end
        ST_TGT: begin
          if (tgt_done) begin
            tgt_req   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_data  <= rd_data;
            rsp_aux   <= rd_aux;
            state     <= ST_IDLE;
          end
        end
        ST_PROC: begin
          if (proc_ack) begin
            proc_req  <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            rsp_aux   <= '0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (tgt_req || proc_req) |-> !req_ready); // R8
  AST_NO_DUAL_PENDING: assert property (@(posedge clk) disable iff (rst)
    !(tgt_req && proc_req)); // R8
  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && !tgt_done) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_wdata) && $stable(tgt_op))); // R8
  AST_PROC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (proc_req && !proc_ack) |=> (proc_req && $stable(proc_entry))); // R9
  AST_REFUSE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (accept && !dec.legal) |=> (rsp_valid && rsp_err && !tgt_req && !proc_req)); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == 64'd0 && rsp_aux == 32'd0)); // R7
  AST_BYTE_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && tgt_size == SZ_8) |-> (rsp_data[63:8] == '0)); // R2
  AST_SA_FIXED_OP: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && tgt_id == TGT_SYSAG && !sa_custom_q) |-> (tgt_op == (tgt_write ? SB_OP_WR : SB_OP_RD))); // R4
  AST_NARROW_WRITE_HI: assert property (@(posedge clk) disable iff (rst)
    (tgt_req && tgt_write && tgt_size != SZ_64) |-> (tgt_wdata[63:32] == '0)); // R6
endmodule

// File: tb/dbg_access_router_tb_top.sv
module dbg_access_router_tb_top;
  localparam int AW = 32;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [7:0] req_cmd = '0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata_hi = '0, req_wdata_lo = '0;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_data;
  logic [31:0] rsp_aux;
  logic tgt_req, tgt_alt, tgt_write;
  logic [2:0] tgt_id;
  logic [1:0] tgt_size;
  logic [AW-1:0] tgt_addr;
  logic [63:0] tgt_wdata;
  logic [7:0] tgt_op;
  logic tgt_done;
  logic [63:0] tgt_rdata;
  logic [31:0] tgt_status;
  logic proc_req, proc_ack;
  logic [AW-1:0] proc_entry;

  always #(CLK_P/2) clk = ~clk;

  dbg_access_router #(.ADDR_W(AW)) dut_i (.*);

  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;

  // stub target bus and procedure engine
  logic [63:0] stub_rd;
  logic [31:0] stub_st;
  logic pend_t, pend_p;
  int lat_t, lat_p, acc_cnt, proc_cnt;
  logic [2:0] o_id; logic o_alt, o_wr; logic [1:0] o_size;
  logic [AW-1:0] o_addr, o_entry; logic [63:0] o_wdata; logic [7:0] o_op;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_t <= 0; pend_p <= 0; tgt_done <= 0; proc_ack <= 0;
      tgt_rdata <= '0; tgt_status <= '0; acc_cnt <= 0; proc_cnt <= 0;
      lat_t <= 0; lat_p <= 0;
    end else begin
      tgt_done <= 0; proc_ack <= 0;
      if (tgt_req && !pend_t && !tgt_done) begin
        pend_t <= 1; lat_t <= int'($urandom % 3); acc_cnt <= acc_cnt + 1;
        o_id <= tgt_id; o_alt <= tgt_alt; o_wr <= tgt_write; o_size <= tgt_size;
        o_addr <= tgt_addr; o_wdata <= tgt_wdata; o_op <= tgt_op;
      end else if (pend_t) begin
        if (lat_t == 0) begin
          pend_t <= 0; tgt_done <= 1; tgt_rdata <= stub_rd; tgt_status <= stub_st;
        end else lat_t <= lat_t - 1;
      end
      if (proc_req && !pend_p && !proc_ack) begin
        pend_p <= 1; lat_p <= int'($urandom % 3); proc_cnt <= proc_cnt + 1; o_entry <= proc_entry;
      end else if (pend_p) begin
        if (lat_p == 0) begin pend_p <= 0; proc_ack <= 1; end
        else lat_p <= lat_p - 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent reference model of the requirements
  task automatic model(input bit w, input logic [7:0] c, input logic [31:0] hi, input logic [31:0] lo,
                       output bit legal, output bit prc, output logic [2:0] id, output bit alt,
                       output logic [1:0] sz, output logic [7:0] op);
    legal = 1; prc = 0; id = 0; alt = 0; sz = 3; op = 0;
    case (c)
      8'h00: id = 0;
      8'h08: begin id = 1; sz = 2; op = w ? 8'h07 : 8'h05; end
      8'h10: id = 2;
      8'h40: id = 3;
      8'h80: begin id = 3; alt = 1; end
      8'h18: begin id = 4; sz = 0; end
      8'h48: begin id = 4; sz = 1; end
      8'h50: begin id = 4; sz = 2; end
      8'h58: id = 4;
      8'hC8: begin legal = w; id = 1; sz = 2; op = hi[7:0]; end
      8'hD0: begin legal = w; id = 5; sz = 2; op = 8'h07; end
      8'hD8: begin legal = w; prc = 1; end
      default: legal = 0;
    endcase
  endtask

  function automatic logic [63:0] msk(input logic [1:0] s);
    return (s == 3) ? '1 : ((64'd1 << (8 << s)) - 64'd1);
  endfunction

  task automatic run_req(input bit w, input logic [7:0] c, input logic [AW-1:0] a,
                         input logic [31:0] hi, input logic [31:0] lo);
    bit legal, prc, alt, rdy_bad;
    logic [2:0] id; logic [1:0] sz; logic [7:0] op;
    logic [63:0] e_data, e_wd; logic [31:0] e_aux;
    int lat, a0, p0;
    model(w, c, hi, lo, legal, prc, id, alt, sz, op);
    stub_rd = {$urandom, $urandom};
    stub_st = $urandom;
    @(negedge clk);
    a0 = acc_cnt; p0 = proc_cnt;
    req_valid = 1; req_write = w; req_cmd = c; req_addr = a; req_wdata_hi = hi; req_wdata_lo = lo;
    while (!req_ready) @(negedge clk);
    lat = 0; rdy_bad = 0;
    forever begin
      @(negedge clk);
      req_valid = 0;
      lat++;
      if (rsp_valid || lat > 40) break;
      if (req_ready) rdy_bad = 1;
    end
    check(rsp_valid, "R11 response arrives", {63'd0, rsp_valid}, 64'd1);
    check(!rdy_bad, "R8 ready low while in flight", {63'd0, rdy_bad}, 64'd0);
    if (!legal) begin
      check(rsp_err && rsp_data == 0 && rsp_aux == 0, "R7 refused result",
            {rsp_err, rsp_data[30:0], rsp_aux}, 64'h8000_0000_0000_0000);
      check(lat == 1, "R7 refuse latency", lat, 1);
      check(acc_cnt == a0 && proc_cnt == p0, "R7 no access", acc_cnt + proc_cnt, a0 + p0);
    end else if (prc) begin
      check(!rsp_err && rsp_data == 0, "R9 proc result", rsp_data, 0);
      check(proc_cnt == p0 + 1 && acc_cnt == a0, "R9 proc issued", proc_cnt, p0 + 1);
      check(o_entry == a, "R9 entry point", o_entry, a);
    end else begin
      e_wd = w ? ((c == 8'hC8) ? {32'd0, lo} : ({hi, lo} & msk(sz))) : 64'd0;
      e_data = w ? 64'd0 : (stub_rd & msk(sz));
      e_aux = (id == 1) ? stub_st : e_data[63:32];
      check(acc_cnt == a0 + 1, "R8 one access", acc_cnt, a0 + 1);
      check(o_id == id && o_alt == alt && o_size == sz && o_wr == w && o_addr == a, "R1 route",
            {o_id, o_alt, o_size, o_addr}, {id, alt, sz, a});
      check(o_op == op, (c == 8'hC8) ? "R5 opcode" : (c == 8'hD0) ? "R10 opcode" : "R4 opcode", o_op, op);
      if (w) check(o_wdata == e_wd, (c == 8'hC8) ? "R5 write data" : "R6 write data", o_wdata, e_wd);
      check(!rsp_err && rsp_data == e_data, "R2 read data", rsp_data, e_data);
      check(rsp_aux == e_aux, (id == 1) ? "R4 status in aux" : "R3 aux mirror", rsp_aux, e_aux);
    end
  endtask

  logic [7:0] codes [12] = '{8'h00, 8'h08, 8'h10, 8'h18, 8'h40, 8'h48, 8'h50, 8'h58, 8'h80, 8'hC8, 8'hD0, 8'hD8};

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    check(req_ready && !rsp_valid && !tgt_req && !proc_req, "R11 reset state",
          {req_ready, rsp_valid, tgt_req, proc_req}, 64'h8);
    // directed corners
    run_req(0, 8'h18, 32'h60, 0, 0);                       // R2 byte port read with garbage above
    run_req(0, 8'h08, 32'h1234, 0, 0);                     // R4 agent read, status in aux
    run_req(1, 8'h08, 32'h1238, 32'hDEAD_BEEF, 32'h0BAD_F00D); // R4 R6 agent write
    run_req(1, 8'hC8, 32'h40, 32'h0000_00A5, 32'h5555_AAAA);   // R5
    run_req(1, 8'hD0, 32'h7, 32'hFFFF_FFFF, 32'h1);        // R10
    run_req(1, 8'h58, 32'h80, 32'h1111_2222, 32'h3333_4444); // R6 full width
    run_req(1, 8'h48, 32'h82, 32'hFFFF_FFFF, 32'hABCD_1234); // R6 narrow
    run_req(0, 8'h80, 32'hB800, 0, 0);                     // R1 second window
    run_req(0, 8'hC8, 32'h0, 0, 0);                        // R7 write-only in read
    run_req(0, 8'hD8, 32'h0, 0, 0);                        // R7
    run_req(1, 8'h33, 32'h0, 0, 0);                        // R7 unknown
    run_req(1, 8'hD8, 32'h0000_1F40, 0, 0);                // R9
    for (int i = 0; i < 300; i++) begin
      logic [7:0] c;
      c = ($urandom % 6 == 0) ? 8'($urandom) : codes[$urandom % 12];
      run_req(1'($urandom), c, $urandom, $urandom, $urandom);
    end
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done_flag) begin
      done_flag = 1;
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule